// File: doc/BRIEF.md
# Exception Vector Base Register with Upper-Bit Write Gate

This block is the control register that holds the base address from which a processor builds its exception vectors. Software updates it through a register-move port: a data word plus a one-cycle write strobe. Which bits a write may change depends on a gate flag at bit 11, and that flag is read from the value already stored, never from the incoming word. With the gate closed, only a middle window of address bits can change, so code that predates the gate cannot move the base out of the low address region. With the gate open, every bit from 11 upward can be written.

The register is built for either a 32-bit or a 64-bit machine, chosen by a width parameter. A second parameter decides whether the gate flag can be written at all. Bits 10:0 are not address bits. They are loaded at reset from a constant identification input and no write changes them afterwards.

The stored value goes straight to the vector generator. A read port returns either a 32-bit view, sign-extended to the data width, or the full stored value.

Top module: `ebase_reg`

## Requirements
- R1: During reset the register loads a base with bit 31 set and bits 30:11 clear. In the 64-bit build, bit 31 is copied into bits 63:32, giving 0xFFFFFFFF_80000000. Bits 10:0 take the value of `id_bits`.
- R2: When the stored gate flag (bit 11) is 0, a write copies bits 29:11 of `wr_data` into the register. Every bit above 29 keeps its value.
- R3: When the stored gate flag is 1 and the gate is writable, a write copies every bit from 11 up to the top bit of `wr_data` into the register.
- R4: The gate decision uses the stored flag, not the flag in the incoming word. A write that sets bit 11 while the stored flag is 0 changes no bit above 29. Only the next write can use the opened gate.
- R5: No write ever changes bits 10:0. They keep the identification value loaded at reset.
- R6: A write takes effect on the clock edge that samples the strobe. A read in that same cycle returns the old value. A cycle with no strobe leaves the register unchanged.
- R7: With `rd_dw` = 0, `rd_data` returns bits 31:0 of the register, with bit 31 copied into every higher bit.
- R8: With `rd_dw` = 1 in the 64-bit build, `rd_data` returns the full stored value unchanged.
- R9: When the gate is built as not writable (GATE_WRITABLE = 0), bit 11 stays 0. Every write then follows R2 for bits 29:12, and bits above 29 never change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| id_bits | input | LOW_W (11) | Constant identification value for bits 10:0, loaded at reset |
| wr_en | input | 1 | Write strobe from the register-move port |
| wr_data | input | DW | Write data word |
| rd_dw | input | 1 | Read format: 0 = sign-extended 32-bit view, 1 = full width |
| rd_data | output | DW | Formatted read value of the current register |
| base_out | output | DW | Current base value, sent to the vector generator |

## Verification
Every cycle, the assertions check the write rules, the read format and the locked flag:
- a cycle with no strobe leaves the register unchanged;
- a write always loads the window bits 29:12;
- the bits above 29 change only under a gate that was already open in the cycle before;
- bits 10:0 never move;
- both read formats match the stored value;
- a gate built as not writable never shows a set flag.

Some behaviour only the bench's scenarios can show:
- the reset pattern itself;
- the two-write sequence needed to open the gate and move the upper bits;
- a read that returns the old value while a write is in flight;
- sign extension of a 32-bit view whose bit 31 is clear while higher bits are set.

// File: rtl/ebase_pkg.sv
package ebase_pkg;

    // Position of the gate flag and width of the fixed identification field
    localparam int GATE_BIT  = 11;
    localparam int LOW_W     = 11;
    // Top bit of the window that stays writable while the gate is closed
    localparam int WIN_TOP   = 29;

    typedef enum logic {
        RD_WORD = 1'b0,
        RD_FULL = 1'b1
    } rd_fmt_t;

    typedef enum logic {
        GATE_SHUT = 1'b0,
        GATE_OPEN = 1'b1
    } gate_state_t;

    // Control bundle that travels from the gate decision into the merge step
    typedef struct packed {
        logic        strobe;
        gate_state_t gate;
    } wr_ctl_t;

    // Window of bits writable while the gate is closed, optionally with the flag itself
    function automatic logic [63:0] shut_mask(input logic flag_writable);
        logic [63:0] m;
        m = '0;
        for (int b = GATE_BIT; b <= WIN_TOP; b++) begin
            m[b] = 1'b1;
        end
        if (!flag_writable) begin
            m[GATE_BIT] = 1'b0;
        end
        return m;
    endfunction

    // Every bit above the identification field
    function automatic logic [63:0] open_mask();
        logic [63:0] m;
        m = '1;
        m[LOW_W-1:0] = '0;
        return m;
    endfunction

    function automatic logic [63:0] sext_word(input logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

endpackage

// File: rtl/ebase_gate.sv
module ebase_gate
    import ebase_pkg::*;
#(
    parameter bit GATE_WRITABLE = 1'b1
) (
    input  logic    stored_flag,
    input  logic    wr_en,
    output wr_ctl_t ctl
);
    // The gate follows the flag already held, never the incoming data
    always_comb begin
        ctl.strobe = wr_en;
        if (GATE_WRITABLE && stored_flag) begin
            ctl.gate = GATE_OPEN;
        end else begin
            ctl.gate = GATE_SHUT;
        end
    end
endmodule

// File: rtl/ebase_wmerge.sv
module ebase_wmerge
    import ebase_pkg::*;
#(
    parameter int DW            = 64,
    parameter bit GATE_WRITABLE = 1'b1
) (
    input  wr_ctl_t       ctl,
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] nxt
);
    localparam logic [63:0] SHUT64 = shut_mask(GATE_WRITABLE);
    localparam logic [63:0] OPEN64 = open_mask();
    localparam logic [DW-1:0] SHUT_M = SHUT64[DW-1:0];
    localparam logic [DW-1:0] OPEN_M = OPEN64[DW-1:0];

    logic [DW-1:0] wmask;

    always_comb begin
        unique case (ctl.gate)
            GATE_OPEN: wmask = OPEN_M;
            default:   wmask = SHUT_M;
        endcase
        if (ctl.strobe) begin
            nxt = (cur & ~wmask) | (wdata & wmask);
        end else begin
            nxt = cur;
        end
    end
endmodule

// File: rtl/ebase_store.sv
module ebase_store
    import ebase_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LOW_W-1:0] id_bits,
    input  logic [DW-1:0]    nxt,
    output logic [DW-1:0]    q
);
    localparam logic [63:0] RST64 = sext_word(32'h8000_0000);
    localparam logic [DW-1:0] RST_UP = RST64[DW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= {RST_UP[DW-1:LOW_W], id_bits};
        end else begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/ebase_rdfmt.sv
module ebase_rdfmt
    import ebase_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0] q,
    input  logic          rd_dw,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] word_view;
    rd_fmt_t       fmt;

    generate
        if (DW > 32) begin : g_wide
            assign word_view = {{(DW-32){q[31]}}, q[31:0]};
        end else begin : g_narrow
            assign word_view = q;
        end
    endgenerate

    always_comb begin
        fmt = rd_fmt_t'(rd_dw);
        unique case (fmt)
            RD_FULL: rd_data = q;
            default: rd_data = word_view;
        endcase
    end
endmodule

// File: rtl/ebase_reg.sv
module ebase_reg
    import ebase_pkg::*;
#(
    parameter int DW            = 64,
    parameter bit GATE_WRITABLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LOW_W-1:0] id_bits,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_dw,
    output logic [DW-1:0]    rd_data,
    output logic [DW-1:0]    base_out
);
    localparam bool_ok = (DW == 32) || (DW == 64);

    wr_ctl_t       ctl;
    logic [DW-1:0] cur_q;
    logic [DW-1:0] nxt_d;

    initial begin
        if (!bool_ok) $display("ebase_reg: DW must be 32 or 64");
    end

    ebase_gate #(.GATE_WRITABLE(GATE_WRITABLE)) u_gate (
        .stored_flag (cur_q[GATE_BIT]),
        .wr_en       (wr_en),
        .ctl         (ctl)
    );

    ebase_wmerge #(.DW(DW), .GATE_WRITABLE(GATE_WRITABLE)) u_merge (
        .ctl   (ctl),
        .cur   (cur_q),
        .wdata (wr_data),
        .nxt   (nxt_d)
    );

    ebase_store #(.DW(DW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .id_bits (id_bits),
        .nxt     (nxt_d),
        .q       (cur_q)
    );

    ebase_rdfmt #(.DW(DW)) u_rd (
        .q       (cur_q),
        .rd_dw   (rd_dw),
        .rd_data (rd_data)
    );

    assign base_out = cur_q;
endmodule

// File: rtl/ebase_reg_chk.sv
module ebase_reg_chk #(
    parameter int DW            = 64,
    parameter bit GATE_WRITABLE = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [DW-1:0] wr_data,
    input logic          rd_dw,
    input logic [DW-1:0] rd_data,
    input logic [DW-1:0] base_out
);
    logic [DW-1:0] word_ref;
    assign word_ref = DW'({{32{base_out[31]}}, base_out[31:0]});

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(base_out)); // R6

    AST_LOW_FIXED: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(base_out[10:0])); // R5

    AST_WINDOW_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> base_out[29:12] == $past(wr_data[29:12])); // R2

    AST_UPPER_SHUT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !(GATE_WRITABLE && base_out[11])) |=> $stable(base_out[DW-1:30])); // R4

    AST_UPPER_OPEN: assert property (@(posedge clk) disable iff (rst)
        (wr_en && GATE_WRITABLE && base_out[11]) |=>
            base_out[DW-1:11] == $past(wr_data[DW-1:11])); // R3

    AST_RD_WORD: assert property (@(posedge clk) disable iff (rst)
        !rd_dw |-> rd_data == word_ref); // R7

    AST_RD_FULL: assert property (@(posedge clk) disable iff (rst)
        rd_dw |-> rd_data == base_out); // R8

    generate
        if (!GATE_WRITABLE) begin : g_locked
            AST_FLAG_LOCKED: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> !base_out[11]); // R9
        end
    endgenerate
endmodule

bind ebase_reg ebase_reg_chk #(.DW(DW), .GATE_WRITABLE(GATE_WRITABLE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_dw    (rd_dw),
    .rd_data  (rd_data),
    .base_out (base_out)
);

// File: tb/ebase_reg_tb_top.sv
`timescale 1ns/100ps
module ebase_reg_tb_top;

    localparam logic [10:0] ID_A = 11'h5A3;
    localparam logic [10:0] ID_B = 11'h2C1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        rd_dw = 1'b0;
    logic [63:0] rd64, base64;
    logic [31:0] rd32, base32;

    always #2.5 clk = ~clk;

    ebase_reg #(.DW(64), .GATE_WRITABLE(1'b1)) dut_i (
        .clk(clk), .rst(rst), .id_bits(ID_A), .wr_en(wr_en),
        .wr_data(wr_data), .rd_dw(rd_dw), .rd_data(rd64), .base_out(base64)
    );

    ebase_reg #(.DW(32), .GATE_WRITABLE(1'b0)) dut_nw (
        .clk(clk), .rst(rst), .id_bits(ID_B), .wr_en(wr_en),
        .wr_data(wr_data[31:0]), .rd_dw(rd_dw), .rd_data(rd32), .base_out(base32)
    );

    typedef struct {
        logic [63:0] rd_a;
        logic [63:0] base_a;
        logic [31:0] rd_b;
        logic [31:0] base_b;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0;
    int          n_err = 0;
    logic [63:0] m64;
    logic [31:0] m32;

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Model of the write rules, written from the requirements
    function automatic logic [63:0] model_wr(input logic [63:0] cur, input logic [63:0] d,
                                             input bit gw, input int w);
        logic [63:0] wm;
        if (gw && cur[11]) wm = 64'hFFFF_FFFF_FFFF_F800;
        else if (gw)       wm = 64'h0000_0000_3FFF_F800;
        else               wm = 64'h0000_0000_3FFF_F000;
        if (w == 32) wm = wm & 64'h0000_0000_FFFF_FFFF;
        return (cur & ~wm) | (d & wm);
    endfunction

    task automatic cycle(input logic we, input logic [63:0] d, input logic rdw, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        wr_en   = we;
        wr_data = d;
        rd_dw   = rdw;
        e.rd_a   = rdw ? m64 : {{32{m64[31]}}, m64[31:0]};
        e.base_a = m64;
        e.rd_b   = m32;
        e.base_b = m32;
        e.tag    = tag;
        sb.push_back(e);
        if (we) begin
            m64 = model_wr(m64, d, 1'b1, 64);
            m32 = 32'(model_wr({32'h0, m32}, d, 1'b0, 32));
        end
    endtask

    // Monitor: compare the outputs of each driven cycle at the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            string tb;
            e  = sb.pop_front();
            tb = (e.tag == "R1") ? "R1" : "R9";
            chk(rd64, e.rd_a, e.tag, "rd_data 64-bit build");
            chk(base64, e.base_a, e.tag, "base_out 64-bit build");
            chk({32'h0, rd32}, {32'h0, e.rd_b}, tb, "rd_data locked 32-bit build");
            chk({32'h0, base32}, {32'h0, e.base_b}, tb, "base_out locked 32-bit build");
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        m64 = {32'hFFFF_FFFF, 32'h8000_0000} | {53'h0, ID_A};
        m32 = 32'h8000_0000 | {21'h0, ID_B};
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset value, both read formats
        cycle(1'b0, 64'h0, 1'b1, "R1");
        cycle(1'b0, 64'h0, 1'b0, "R1");
        // R6: write issued, the same cycle still shows the old value
        cycle(1'b1, 64'h0123_4567_FFFF_F7FF, 1'b1, "R6");
        // R2: closed gate, only the 29:11 window moved
        cycle(1'b0, 64'h0, 1'b1, "R2");
        // R4: data sets the flag while the stored flag is 0, upper bits stay
        cycle(1'b1, 64'h7777_0000_C000_0800, 1'b1, "R4");
        cycle(1'b0, 64'h0, 1'b1, "R4");
        // R3/R5: gate now open, all upper bits load, low field untouched
        cycle(1'b1, 64'h1234_5678_9ABC_DFFF, 1'b1, "R3");
        cycle(1'b0, 64'h0, 1'b1, "R5");
        // R6: no strobe, value holds
        cycle(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R6");
        // R7: 32-bit view with bit 31 set
        cycle(1'b0, 64'h0, 1'b0, "R7");
        // Open write clears bit 31 of the word and the flag
        cycle(1'b1, 64'h8000_0000_7000_0000, 1'b1, "R3");
        cycle(1'b0, 64'h0, 1'b0, "R7");
        cycle(1'b0, 64'h0, 1'b1, "R8");
        // R2: flag now clear, all-ones write touches only the window
        cycle(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R2");
        cycle(1'b0, 64'h0, 1'b1, "R2");
        // R3: flag reopened by that write, zero write clears the upper bits
        cycle(1'b1, 64'h0, 1'b1, "R3");
        cycle(1'b0, 64'h0, 1'b0, "R3");
        cycle(1'b0, 64'h0, 1'b1, "R8");
        @(posedge clk);
        @(posedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule